// File: doc/BRIEF.md
# Debug Memory-Access Transaction Parser

This block sits behind a single-wire debug frame receiver and follows the debug transaction that a stream of acknowledged frames builds up. Each transaction opens with a command frame. A read or write command is followed by a byte-count frame, then three address frames, and then the number of data frames that the count gave. The parser reports several results as registered outputs: the command type, the assembled address with a one-cycle valid strobe, the number of data bytes still expected, and each data byte with its direction bit and a strobe. The parser does not perform any memory access itself.

The `cmd_phase` output tells the frame receiver which frame length to expect next. It is high whenever the next frame is a short command frame and low while byte frames are expected. Frames that were not acknowledged have no effect. A synchronization-reset input puts the parser back in command phase at any point of a transaction.

Top module: `dbg_txn_parser`

## Requirements
- R1: After reset, `cmd_phase` is 1, `count_left` and `addr` are 0, and `cmd_strobe`, `unknown_strobe`, `addr_valid` and `data_strobe` are all 0.
- R2: An accepted frame in command phase pulses `cmd_strobe` for one cycle, on the cycle after the frame. On that cycle `cmd_kind` changes to 0 for code 0x00 (system reset), 1 for code 0x01 (read), 2 for code 0x02 (write) and 3 for any other code. `cmd_kind` then holds that value.
- R3: After a system-reset command or an unknown command, `cmd_phase` stays 1. An unknown code also pulses `unknown_strobe` for one cycle, and the other codes do not.
- R4: After a read or write command, `cmd_phase` drops to 0. The next accepted frame loads its byte into `count_left`.
- R5: The following three accepted frames build `addr` with the most significant byte first. `addr_valid` pulses for exactly one cycle, on the cycle after the third address frame, and `addr` then holds the full 24-bit value.
- R6: Each data frame after the address pulses `data_strobe` for one cycle. On that cycle `data_byte` equals the frame byte, `data_dir` equals the frame's start bit, and `count_left` is one less than before.
- R7: The data frame that takes `count_left` to 0 sets `cmd_phase` back to 1, on the same cycle as its `data_strobe`.
- R8: When the byte count is 0, `cmd_phase` returns to 1 on the same cycle as `addr_valid`, and no data strobe follows.
- R9: A frame with `frm_ack` = 0 changes nothing. No strobe fires, and `count_left` and `cmd_phase` keep their values.
- R10: `sync_rst` puts the parser in command phase on the next cycle. It takes priority over a frame presented in the same cycle, and that frame produces no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_rst | input | 1 | Synchronization-frame reset, forces command phase |
| frm_valid | input | 1 | One-cycle strobe: a frame has completed |
| frm_ack | input | 1 | Acknowledge bit of that frame (1 = acknowledged) |
| frm_dir | input | 1 | Start bit of that frame (direction) |
| frm_data | input | 8 | Payload byte of that frame |
| cmd_phase | output | 1 | 1 when the next frame is a command frame |
| cmd_kind | output | 2 | Last command: 0 system reset, 1 read, 2 write, 3 unknown |
| cmd_strobe | output | 1 | Pulses when a command is decoded |
| unknown_strobe | output | 1 | Pulses when an unknown command is decoded |
| count_left | output | 8 | Data bytes still expected |
| addr | output | 24 | Assembled address |
| addr_valid | output | 1 | Pulses when the third address byte is in |
| data_byte | output | 8 | Last data byte |
| data_dir | output | 1 | Direction of the last data byte |
| data_strobe | output | 1 | Pulses for each data byte |

## Verification
The assertions check properties that must hold on every cycle:
- strobes are mutually exclusive and each one traces back to an acknowledged frame;
- an unacknowledged frame leaves the count and the phase unchanged;
- `sync_rst` always lands the parser in command phase;
- an unknown command or the final data byte leaves command phase asserted;
- the remaining count never underflows.

Some behaviour can only be shown by the bench's scenarios: the exact mapping of every one of the 256 command codes, the most-significant-byte-first assembly of the address, and the value and direction of each data byte. The same holds for the zero-count, one-count and longer transactions, and for the cycle on which each strobe appears.

// File: rtl/dbg_txn_pkg.sv
package dbg_txn_pkg;
  typedef enum logic [1:0] {
    PH_CMD  = 2'd0,
    PH_CNT  = 2'd1,
    PH_ADDR = 2'd2,
    PH_DATA = 2'd3
  } phase_t;

  typedef enum logic [1:0] {
    CK_SYSRST  = 2'd0,
    CK_READ    = 2'd1,
    CK_WRITE   = 2'd2,
    CK_UNKNOWN = 2'd3
  } cmd_kind_t;
endpackage

// File: rtl/dbg_cmd_decode.sv
module dbg_cmd_decode
  import dbg_txn_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] code,
  output cmd_kind_t         kind,
  output logic              opens_txn
);
  always_comb begin
    if (code == DATA_W'(0))      kind = CK_SYSRST;
    else if (code == DATA_W'(1)) kind = CK_READ;
    else if (code == DATA_W'(2)) kind = CK_WRITE;
    else                         kind = CK_UNKNOWN;
    opens_txn = (kind == CK_READ) || (kind == CK_WRITE);
  end
endmodule

// File: rtl/dbg_addr_collect.sv
module dbg_addr_collect #(
  parameter int DATA_W     = 8,
  parameter int ADDR_BYTES = 3
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         clear,
  input  logic                         shift_en,
  input  logic [DATA_W-1:0]            byte_in,
  output logic [DATA_W*ADDR_BYTES-1:0] addr,
  output logic                         last
);
  localparam int ADDR_W = DATA_W * ADDR_BYTES;
  localparam int IDX_W  = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(ADDR_BYTES - 1);

  logic [IDX_W-1:0] idx;

  assign last = (idx == IDX_LAST);

  always_ff @(posedge clk) begin
    if (rst || clear) idx <= '0;
    else if (shift_en) idx <= last ? '0 : idx + IDX_W'(1);
  end

  generate
    if (ADDR_BYTES > 1) begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) addr <= '0;
        else if (shift_en) addr <= {addr[ADDR_W-DATA_W-1:0], byte_in};
      end
    end else begin : g_single
      always_ff @(posedge clk) begin
        if (rst) addr <= '0;
        else if (shift_en) addr <= byte_in;
      end
    end
  endgenerate

  // R5
  idx_range_chk: assert property (@(posedge clk) disable iff (rst)
    idx <= IDX_LAST);
endmodule

// File: rtl/dbg_count_track.sv
module dbg_count_track #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic [CNT_W-1:0] remaining,
  output logic             is_one,
  output logic             is_zero
);
  assign is_one  = (remaining == CNT_W'(1));
  assign is_zero = (remaining == '0);

  always_ff @(posedge clk) begin
    if (rst || clear) remaining <= '0;
    else if (load)    remaining <= load_val;
    else if (dec)     remaining <= remaining - CNT_W'(1);
  end

  // R6
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    dec |-> !is_zero);
endmodule

// File: rtl/dbg_txn_parser.sv
module dbg_txn_parser
  import dbg_txn_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int ADDR_BYTES = 3
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         sync_rst,
  input  logic                         frm_valid,
  input  logic                         frm_ack,
  input  logic                         frm_dir,
  input  logic [DATA_W-1:0]            frm_data,
  output logic                         cmd_phase,
  output logic [1:0]                   cmd_kind,
  output logic                         cmd_strobe,
  output logic                         unknown_strobe,
  output logic [DATA_W-1:0]            count_left,
  output logic [DATA_W*ADDR_BYTES-1:0] addr,
  output logic                         addr_valid,
  output logic [DATA_W-1:0]            data_byte,
  output logic                         data_dir,
  output logic                         data_strobe
);
  localparam int ADDR_W = DATA_W * ADDR_BYTES;

  phase_t    phase;
  cmd_kind_t dec_kind;
  logic      dec_opens;
  logic      go;
  logic      addr_last, cnt_one, cnt_zero;
  logic [ADDR_W-1:0] addr_int;

  assign go        = frm_valid && frm_ack && !sync_rst;
  assign cmd_phase = (phase == PH_CMD);
  assign addr      = addr_int;

  dbg_cmd_decode #(.DATA_W(DATA_W)) u_dec (
    .code      (frm_data),
    .kind      (dec_kind),
    .opens_txn (dec_opens)
  );

  dbg_count_track #(.CNT_W(DATA_W)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .clear     (sync_rst),
    .load      (go && phase == PH_CNT),
    .load_val  (frm_data),
    .dec       (go && phase == PH_DATA),
    .remaining (count_left),
    .is_one    (cnt_one),
    .is_zero   (cnt_zero)
  );

  dbg_addr_collect #(.DATA_W(DATA_W), .ADDR_BYTES(ADDR_BYTES)) u_addr (
    .clk      (clk),
    .rst      (rst),
    .clear    (sync_rst || (go && phase == PH_CNT)),
    .shift_en (go && phase == PH_ADDR),
    .byte_in  (frm_data),
    .addr     (addr_int),
    .last     (addr_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase          <= PH_CMD;
      cmd_kind       <= 2'(CK_SYSRST);
      cmd_strobe     <= 1'b0;
      unknown_strobe <= 1'b0;
      addr_valid     <= 1'b0;
      data_byte      <= '0;
      data_dir       <= 1'b0;
      data_strobe    <= 1'b0;
    end else begin
      cmd_strobe     <= 1'b0;
      unknown_strobe <= 1'b0;
      addr_valid     <= 1'b0;
      data_strobe    <= 1'b0;
      if (sync_rst) begin
        phase <= PH_CMD;
      end else if (go) begin
        unique case (phase)
          PH_CMD: begin
            cmd_kind       <= 2'(dec_kind);
            cmd_strobe     <= 1'b1;
            unknown_strobe <= (dec_kind == CK_UNKNOWN);
            if (dec_opens) phase <= PH_CNT;
          end
          PH_CNT: phase <= PH_ADDR;
          PH_ADDR: begin
            if (addr_last) begin
              addr_valid <= 1'b1;
              phase      <= cnt_zero ? PH_CMD : PH_DATA;
            end
          end
          PH_DATA: begin
            data_byte   <= frm_data;
            data_dir    <= frm_dir;
            data_strobe <= 1'b1;
            if (cnt_one) phase <= PH_CMD;
          end
          default: phase <= PH_CMD;
        endcase
      end
    end
  end

  // R10
  sync_to_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    sync_rst |=> cmd_phase && !data_strobe && !addr_valid && !cmd_strobe);

  // R9
  nack_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (frm_valid && !frm_ack && !sync_rst) |=>
      $stable(count_left) && $stable(cmd_phase) && !data_strobe && !addr_valid && !cmd_strobe);

  // R6
  data_from_frame_chk: assert property (@(posedge clk) disable iff (rst)
    data_strobe |-> $past(frm_valid && frm_ack));

  // R7
  last_data_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    (data_strobe && count_left == '0) |-> cmd_phase);

  // R3
  unknown_stays_chk: assert property (@(posedge clk) disable iff (rst)
    unknown_strobe |-> cmd_phase && cmd_strobe);

  // R5
  addr_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    addr_valid |=> !addr_valid);

  // R2
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cmd_strobe, addr_valid, data_strobe}));
endmodule

// File: tb/dbg_txn_parser_test.sv
`timescale 1ns/1ps
module dbg_txn_parser_test;
  logic        clk = 1'b0;
  logic        rst, sync_rst, frm_valid, frm_ack, frm_dir;
  logic [7:0]  frm_data;
  logic        cmd_phase, cmd_strobe, unknown_strobe, addr_valid, data_dir, data_strobe;
  logic [1:0]  cmd_kind;
  logic [7:0]  count_left, data_byte;
  logic [23:0] addr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  dbg_txn_parser uut (
    .clk(clk), .rst(rst), .sync_rst(sync_rst), .frm_valid(frm_valid),
    .frm_ack(frm_ack), .frm_dir(frm_dir), .frm_data(frm_data),
    .cmd_phase(cmd_phase), .cmd_kind(cmd_kind), .cmd_strobe(cmd_strobe),
    .unknown_strobe(unknown_strobe), .count_left(count_left), .addr(addr),
    .addr_valid(addr_valid), .data_byte(data_byte), .data_dir(data_dir),
    .data_strobe(data_strobe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // drive at a falling edge, return at the next falling edge (outputs updated)
  task automatic send(input logic [7:0] d, input logic dir, input logic ack, input logic sy);
    frm_data = d; frm_dir = dir; frm_ack = ack; frm_valid = 1'b1; sync_rst = sy;
    @(negedge clk);
    frm_valid = 1'b0; frm_ack = 1'b0; sync_rst = 1'b0;
  endtask

  task automatic do_sync();
    sync_rst = 1'b1;
    @(negedge clk);
    sync_rst = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; sync_rst = 1'b0; frm_valid = 1'b0; frm_ack = 1'b0;
    frm_dir = 1'b0; frm_data = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    chk("R1 cmd_phase", cmd_phase, 1);
    chk("R1 count_left", count_left, 0);
    chk("R1 addr", addr, 0);
    chk("R1 strobes", {cmd_strobe, unknown_strobe, addr_valid, data_strobe}, 0);

    // R2 / R3 / R4: sweep every command code
    for (int c = 0; c < 256; c++) begin
      logic [1:0] ek;
      logic opens;
      ek = (c == 0) ? 2'd0 : (c == 1) ? 2'd1 : (c == 2) ? 2'd2 : 2'd3;
      opens = (c == 1) || (c == 2);
      send(8'(c), 1'b0, 1'b1, 1'b0);
      chk("R2 cmd_strobe", cmd_strobe, 1);
      chk("R2 cmd_kind", cmd_kind, ek);
      chk("R3 unknown_strobe", unknown_strobe, (c > 2) ? 1 : 0);
      chk(opens ? "R4 phase after read/write" : "R3 stays in command phase", cmd_phase, opens ? 0 : 1);
      @(negedge clk);
      chk("R2 strobe one cycle", cmd_strobe, 0);
      chk("R2 cmd_kind holds", cmd_kind, ek);
      if (opens) begin
        do_sync();
        chk("R10 sync returns to command", cmd_phase, 1);
      end
    end

    // R9: unacknowledged command frame
    send(8'h01, 1'b0, 1'b0, 1'b0);
    chk("R9 nack cmd strobe", cmd_strobe, 0);
    chk("R9 nack cmd phase", cmd_phase, 1);

    // R4..R8: transactions with several counts
    for (int k = 0; k < 6; k++) begin
      int cnt;
      logic [23:0] a;
      cnt = (k == 0) ? 0 : (k == 1) ? 1 : (k == 2) ? 2 : (k == 3) ? 5 : (k == 4) ? 17 : 255;
      a = 24'(k * 32'h12345 + 32'hA50F30);
      send((k % 2 == 1) ? 8'h01 : 8'h02, 1'b0, 1'b1, 1'b0);
      chk("R2 kind in transaction", cmd_kind, (k % 2 == 1) ? 1 : 2);
      send(8'(cnt), 1'b0, 1'b1, 1'b0);
      chk("R4 count loaded", count_left, cnt);
      chk("R4 byte phase", cmd_phase, 0);
      send(a[23:16], 1'b0, 1'b1, 1'b0);
      chk("R5 no early valid", addr_valid, 0);
      send(a[15:8], 1'b0, 1'b1, 1'b0);
      chk("R5 no early valid", addr_valid, 0);
      send(a[7:0], 1'b0, 1'b1, 1'b0);
      chk("R5 addr_valid", addr_valid, 1);
      chk("R5 addr msb first", addr, a);
      chk(cnt == 0 ? "R8 zero count to command" : "R5 data phase", cmd_phase, (cnt == 0) ? 1 : 0);
      @(negedge clk);
      chk("R5 single pulse", addr_valid, 0);
      if (cnt == 0) chk("R8 no data strobe", data_strobe, 0);
      for (int i = 0; i < cnt; i++) begin
        logic [7:0] d;
        logic dr;
        d  = 8'(cnt * 13 + i * 7);
        dr = 1'((i + k) & 1);
        send(d, dr, 1'b1, 1'b0);
        chk("R6 data_strobe", data_strobe, 1);
        chk("R6 data_byte", data_byte, d);
        chk("R6 data_dir", data_dir, dr);
        chk("R6 count_left", count_left, cnt - 1 - i);
        chk(i == cnt - 1 ? "R7 back to command" : "R7 still data", cmd_phase, (i == cnt - 1) ? 1 : 0);
      end
    end

    // R9: nack during data phase
    send(8'h02, 1'b0, 1'b1, 1'b0);
    send(8'd3, 1'b0, 1'b1, 1'b0);
    send(8'h11, 1'b0, 1'b1, 1'b0);
    send(8'h22, 1'b0, 1'b1, 1'b0);
    send(8'h33, 1'b0, 1'b1, 1'b0);
    send(8'h5A, 1'b1, 1'b1, 1'b0);
    chk("R6 first byte count", count_left, 2);
    send(8'hC3, 1'b0, 1'b0, 1'b0);
    chk("R9 nack count kept", count_left, 2);
    chk("R9 nack no strobe", data_strobe, 0);
    chk("R9 nack phase kept", cmd_phase, 0);
    chk("R9 data byte kept", data_byte, 8'h5A);

    // R10: sync with a frame in the same cycle
    send(8'hC3, 1'b1, 1'b1, 1'b1);
    chk("R10 sync priority phase", cmd_phase, 1);
    chk("R10 sync priority strobe", data_strobe, 0);
    chk("R10 count cleared", count_left, 0);
    send(8'h00, 1'b0, 1'b1, 1'b0);
    chk("R10 next frame is command", cmd_strobe, 1);
    chk("R10 next kind", cmd_kind, 0);

    // R10: sync during address phase
    send(8'h01, 1'b0, 1'b1, 1'b0);
    send(8'd4, 1'b0, 1'b1, 1'b0);
    send(8'hAB, 1'b0, 1'b1, 1'b0);
    do_sync();
    chk("R10 sync in address", cmd_phase, 1);
    chk("R10 no addr_valid", addr_valid, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule